// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between a host access port and the command and clock-enable pins of an SDRAM device. A two-bit mode value selects one of four policies: stay awake, self-refresh, power-down or deep power-down. When no access is pending, the block puts the device into the selected low-power state. It issues the entry command in the same cycle that it lowers clock-enable, and in self-refresh it also stops the memory clock. When a host request arrives, the block wakes the device with the exit sequence that belongs to the current state. It grants the access, and once the host reports the access complete it returns the device to the low-power state.

Deep power-down loses the device's contents, so leaving it requires a full re-initialisation. The block raises an init-required flag and holds the grant back until the initialisation engine answers with a one-cycle done pulse. The partial-array, temperature-compensation and drive-strength values are held next to the mode value. They are presented continuously so that the initialisation engine can place them in the extended-mode-register write. A new mode value may be written at any time, but the sequencer adopts it only while the device is awake and idle.

Top module: `sdram_lp_sequencer`

## Requirements
- R1: After reset, sd_cke and sd_clk_en are 1, the command pins show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), acc_gnt and init_required are 0, and the mode and all three parameter outputs are 0.
- R2: While the adopted mode is 00, sd_cke never goes low and no command other than NOP appears. A request is granted one cycle after the edge that samples it (acc_gnt is high after the first such edge).
- R3: Mode 01 (self-refresh) is entered with the auto-refresh command (0,0,0,1) in the cycle that sd_cke first goes low. From the next cycle sd_clk_en is 0 and stays 0 until a request arrives, and sd_cke is low throughout.
- R4: A request in self-refresh first restarts the clock (sd_clk_en high, sd_cke still low) for one cycle, then raises sd_cke and grants after SR_EXIT_CYC further cycles. The grant is therefore high 2+SR_EXIT_CYC edges after the request is first sampled. sd_cke never rises unless the clock ran in the previous cycle.
- R5: Mode 10 (power-down) is entered with NOP (0,1,1,1) in the cycle that sd_cke goes low, and sd_clk_en stays 1 while powered down.
- R6: A request in power-down raises sd_cke at once and grants after PD_EXIT_CYC cycles: the grant is high 1+PD_EXIT_CYC edges after the request is first sampled. The grant is only ever high with sd_cke and sd_clk_en both high, and it stays high until acc_done.
- R7: Mode 11 (deep power-down) is entered with burst-terminate (0,1,1,0) in the cycle that sd_cke goes low. A request then raises init_required with no grant until init_done is sampled high, and the grant is high two edges after that.
- R8: emr_pasr (3 bits), emr_tcsr (2 bits) and emr_ds (2 bits) present the values captured by the last cfg_we write.
- R9: A mode written while the device is in low power does not change the exit sequence of the current state. It is adopted, together with its entry command, only after the next access completes and the sequencer is idle again. After every completed access in a low-power mode, the device re-enters that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the mode and parameter fields |
| cfg_mode | input | 2 | Low-power mode: 00 off, 01 self-refresh, 10 power-down, 11 deep power-down |
| cfg_pasr | input | 3 | Partial-array self-refresh value to capture |
| cfg_tcsr | input | 2 | Temperature-compensated refresh value to capture |
| cfg_ds | input | 2 | Drive-strength value to capture |
| acc_req | input | 1 | Host access request, held until granted |
| acc_gnt | output | 1 | Access granted, device awake |
| acc_done | input | 1 | One-cycle pulse, the granted access has finished |
| init_required | output | 1 | Device left deep power-down and needs initialisation |
| init_done | input | 1 | One-cycle pulse, initialisation finished |
| emr_pasr | output | 3 | Partial-array value for the extended-mode-register write |
| emr_tcsr | output | 2 | Temperature value for the extended-mode-register write |
| emr_ds | output | 2 | Drive-strength value for the extended-mode-register write |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Memory clock enable |
| sd_clk_en | output | 1 | Gate enable for the memory clock |

## Verification
The bench builds the sequencer with SR_EXIT_CYC set to 4 and PD_EXIT_CYC set to 2. This gives four distinct grant latencies: 1 when awake, 3 from power-down, 6 from self-refresh and 7 for the deep power-down path as the bench paces init_done. A latency that is off by one cycle, or an exit sequence taken from the wrong mode, therefore shows up as a wrong number. The small counts also keep every exit window short, so a single run can pass through all four modes and the deferred mode changes between them.

// File: rtl/sdlp_pkg.sv
package sdlp_pkg;

    localparam int PASR_W = 3;
    localparam int TCSR_W = 2;
    localparam int DS_W   = 2;

    typedef enum logic [1:0] {
        LPM_OFF   = 2'b00,
        LPM_SELF  = 2'b01,
        LPM_PDOWN = 2'b10,
        LPM_DEEP  = 2'b11
    } lp_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_ENTER,
        ST_SLEEP,
        ST_CLKUP,
        ST_WAKE,
        ST_REINIT
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_AREF,
        CMD_BST
    } sd_cmd_e;

    typedef struct packed {
        seq_state_e          st;
        lp_mode_e            mode_act;
        lp_mode_e            mode_pend;
        logic [PASR_W-1:0]   pasr;
        logic [TCSR_W-1:0]   tcsr;
        logic [DS_W-1:0]     ds;
    } seq_regs_t;

endpackage

// File: rtl/sdlp_wait_timer.sv
module sdlp_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);

    // R4 / R6: an exit window shrinks by exactly one each cycle
    p_timer_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdlp_cmd_encoder.sv
module sdlp_cmd_encoder
    import sdlp_pkg::*;
(
    input  sd_cmd_e cmd,
    output logic    cs_n,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n
);
    always_comb begin
        case (cmd)
            CMD_AREF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CMD_BST:  {cs_n, ras_n, cas_n, we_n} = 4'b0110;
            default:  {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
    end

    // R3 / R7: chip select is low for every encoded command
    p_cs_low_r3: assert final (cs_n == 1'b0);

endmodule

// File: rtl/sdram_lp_sequencer.sv
module sdram_lp_sequencer
    import sdlp_pkg::*;
#(
    parameter int SR_EXIT_CYC = 8,
    parameter int PD_EXIT_CYC = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_mode,
    input  logic [PASR_W-1:0]    cfg_pasr,
    input  logic [TCSR_W-1:0]    cfg_tcsr,
    input  logic [DS_W-1:0]      cfg_ds,
    input  logic                 acc_req,
    output logic                 acc_gnt,
    input  logic                 acc_done,
    output logic                 init_required,
    input  logic                 init_done,
    output logic [PASR_W-1:0]    emr_pasr,
    output logic [TCSR_W-1:0]    emr_tcsr,
    output logic [DS_W-1:0]      emr_ds,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic                 sd_cke,
    output logic                 sd_clk_en
);
    localparam int MAX_EXIT = (SR_EXIT_CYC > PD_EXIT_CYC) ? SR_EXIT_CYC : PD_EXIT_CYC;
    localparam int TMR_W    = (MAX_EXIT < 2) ? 1 : $clog2(MAX_EXIT);
    localparam logic [TMR_W-1:0] SR_LOAD = TMR_W'(SR_EXIT_CYC - 1);
    localparam logic [TMR_W-1:0] PD_LOAD = TMR_W'(PD_EXIT_CYC - 1);

    seq_regs_t        d, q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    sd_cmd_e          cmd;

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;

        if (cfg_we) begin
            d.mode_pend = lp_mode_e'(cfg_mode);
            d.pasr      = cfg_pasr;
            d.tcsr      = cfg_tcsr;
            d.ds        = cfg_ds;
        end

        case (q.st)
            ST_IDLE: begin
                d.mode_act = q.mode_pend;
                if (acc_req)
                    d.st = ST_ACCESS;
                else if (q.mode_pend != LPM_OFF)
                    d.st = ST_ENTER;
            end
            ST_ACCESS: if (acc_done) d.st = ST_IDLE;
            ST_ENTER:  d.st = ST_SLEEP;
            ST_SLEEP: begin
                if (acc_req) begin
                    case (q.mode_act)
                        LPM_SELF:  d.st = ST_CLKUP;
                        LPM_PDOWN: begin
                            d.st     = ST_WAKE;
                            tmr_load = 1'b1;
                            tmr_val  = PD_LOAD;
                        end
                        LPM_DEEP:  d.st = ST_REINIT;
                        default:   d.st = ST_IDLE;
                    endcase
                end
            end
            ST_CLKUP: begin
                d.st     = ST_WAKE;
                tmr_load = 1'b1;
                tmr_val  = SR_LOAD;
            end
            ST_WAKE:   if (tmr_zero) d.st = ST_ACCESS;
            ST_REINIT: if (init_done) d.st = ST_IDLE;
            default:   d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.mode_act  <= LPM_OFF;
            q.mode_pend <= LPM_OFF;
            q.pasr      <= '0;
            q.tcsr      <= '0;
            q.ds        <= '0;
        end else begin
            q <= d;
        end
    end

    sdlp_wait_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .is_zero  (tmr_zero)
    );

    always_comb begin
        cmd = CMD_NOP;
        if (q.st == ST_ENTER) begin
            if (q.mode_act == LPM_SELF)      cmd = CMD_AREF;
            else if (q.mode_act == LPM_DEEP) cmd = CMD_BST;
        end
    end

    sdlp_cmd_encoder u_enc (
        .cmd   (cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    assign sd_cke        = !(q.st inside {ST_ENTER, ST_SLEEP, ST_CLKUP});
    assign sd_clk_en     = !(q.st == ST_SLEEP && q.mode_act == LPM_SELF);
    assign acc_gnt       = (q.st == ST_ACCESS);
    assign init_required = (q.st == ST_REINIT);
    assign emr_pasr      = q.pasr;
    assign emr_tcsr      = q.tcsr;
    assign emr_ds        = q.ds;

    // R6: a grant only reaches the host while the device is clocked and awake
    p_gnt_awake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> (sd_cke && sd_clk_en));

    // R4: clock-enable rises only after the memory clock ran for a cycle
    p_clk_before_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_cke) |-> $past(sd_clk_en));

    // R3: the clock is stopped only with clock-enable low
    p_clk_stop_cke_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_clk_en |-> !sd_cke);

    // R7: no grant while re-initialisation is outstanding
    p_no_gnt_reinit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_required |-> !acc_gnt);

    // R2: an idle device with low power disabled keeps clock-enable high
    p_off_keeps_cke_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && q.mode_pend == LPM_OFF && !cfg_we) |=> sd_cke);

    // R9: the adopted mode changes only on a pass through idle
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.mode_act));

endmodule

// File: tb/sdram_lp_sequencer_tb.sv
`timescale 1ns/1ps
module sdram_lp_sequencer_tb;
    localparam int SR_N = 4;
    localparam int PD_N = 2;
    localparam logic [3:0] C_NOP  = 4'b0111;
    localparam logic [3:0] C_AREF = 4'b0001;
    localparam logic [3:0] C_BST  = 4'b0110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic [2:0] cfg_pasr = '0;
    logic [1:0] cfg_tcsr = '0;
    logic [1:0] cfg_ds = '0;
    logic acc_req = 1'b0, acc_done = 1'b0, init_done = 1'b0;
    logic acc_gnt, init_required, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_clk_en;
    logic [2:0] emr_pasr;
    logic [1:0] emr_tcsr, emr_ds;

    int checks = 0, errors = 0;
    bit finished = 0;
    int lat_q[$];
    logic [3:0] ent_q[$];

    always #10 clk = ~clk;

    sdram_lp_sequencer #(.SR_EXIT_CYC(SR_N), .PD_EXIT_CYC(PD_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_pasr(cfg_pasr), .cfg_tcsr(cfg_tcsr), .cfg_ds(cfg_ds),
        .acc_req(acc_req), .acc_gnt(acc_gnt), .acc_done(acc_done),
        .init_required(init_required), .init_done(init_done),
        .emr_pasr(emr_pasr), .emr_tcsr(emr_tcsr), .emr_ds(emr_ds),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_cke(sd_cke), .sd_clk_en(sd_clk_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] m, input logic [2:0] p,
                             input logic [1:0] t, input logic [1:0] s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_pasr = p; cfg_tcsr = t; cfg_ds = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: pushes the expected grant latency, then runs one access
    task automatic do_access(input int exp_lat, input bit deep);
        int k = 0;
        lat_q.push_back(exp_lat);
        @(negedge clk);
        acc_req = 1'b1;
        forever begin
            @(negedge clk);
            k++;
            if (acc_gnt) break;
            if (deep && k == 5) begin
                chk(init_required == 1'b1, "R7 init_required", init_required, 1);
                chk(acc_gnt == 1'b0, "R7 no grant before init_done", acc_gnt, 0);
                init_done = 1'b1;
                @(negedge clk);
                k++;
                init_done = 1'b0;
            end
        end
        @(negedge clk);
        acc_req = 1'b0;
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // monitor: grant latency and low-power entry commands
    int  lat_cnt = 0;
    bit  granted = 0;
    logic cke_prev = 1'b1;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (acc_req && !granted) begin
                if (acc_gnt) begin
                    granted = 1;
                    if (lat_q.size() == 0)
                        chk(0, "R2/R4/R6 unexpected grant", lat_cnt, -1);
                    else begin
                        int e;
                        e = lat_q.pop_front();
                        chk(lat_cnt == e, "R2/R4/R6/R7 grant latency", lat_cnt, e);
                    end
                end else begin
                    lat_cnt++;
                end
            end
            if (!acc_req) begin
                lat_cnt = 0;
                granted = 0;
            end
            if (cke_prev && !sd_cke) begin
                if (ent_q.size() == 0)
                    chk(0, "R2/R9 unexpected entry", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, -1);
                else begin
                    logic [3:0] ec;
                    ec = ent_q.pop_front();
                    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == ec, "R3/R5/R7/R9 entry command",
                        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, ec);
                end
            end else if (sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != C_NOP) begin
                chk(0, "R2 stray command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
            end
            cke_prev = sd_cke;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sd_cke == 1'b1, "R1 cke", sd_cke, 1);
        chk(sd_clk_en == 1'b1, "R1 clk_en", sd_clk_en, 1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 command",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk(acc_gnt == 1'b0 && init_required == 1'b0, "R1 gnt/init", {acc_gnt, init_required}, 0);
        chk({emr_pasr, emr_tcsr, emr_ds} == '0, "R1 emr params", {emr_pasr, emr_tcsr, emr_ds}, 0);

        // R2 low power off
        do_access(1, 0);
        repeat (8) @(negedge clk);
        chk(sd_cke == 1'b1, "R2 cke stays high", sd_cke, 1);

        // R3 self-refresh entry, R8 parameters
        ent_q.push_back(C_AREF);
        cfg_write(2'b01, 3'b001, 2'b10, 2'b01);
        repeat (6) @(negedge clk);
        chk(sd_cke == 1'b0, "R3 cke low", sd_cke, 0);
        chk(sd_clk_en == 1'b0, "R3 clock stopped", sd_clk_en, 0);
        chk(emr_pasr == 3'b001, "R8 pasr", emr_pasr, 1);
        chk(emr_tcsr == 2'b10, "R8 tcsr", emr_tcsr, 2);
        chk(emr_ds == 2'b01, "R8 ds", emr_ds, 1);

        // R4 self-refresh exit and re-entry
        ent_q.push_back(C_AREF);
        do_access(2 + SR_N, 0);
        chk(sd_clk_en == 1'b0, "R4 back in self-refresh", sd_clk_en, 0);

        // R9 mode change while in self-refresh
        cfg_write(2'b10, 3'b010, 2'b01, 2'b10);
        repeat (3) @(negedge clk);
        chk(sd_clk_en == 1'b0, "R9 old mode held", sd_clk_en, 0);
        chk(emr_pasr == 3'b010, "R8 pasr rewrite", emr_pasr, 2);
        ent_q.push_back(C_NOP);
        do_access(2 + SR_N, 0);
        chk(sd_cke == 1'b0, "R5 cke low", sd_cke, 0);
        chk(sd_clk_en == 1'b1, "R5 clock runs", sd_clk_en, 1);

        // R6 power-down exit
        ent_q.push_back(C_NOP);
        do_access(1 + PD_N, 0);

        // R9 change to deep power-down while powered down
        cfg_write(2'b11, 3'b010, 2'b01, 2'b10);
        ent_q.push_back(C_BST);
        do_access(1 + PD_N, 0);
        chk(sd_cke == 1'b0, "R7 cke low in deep power-down", sd_cke, 0);

        // R7 deep power-down exit through re-initialisation
        ent_q.push_back(C_BST);
        do_access(7, 1);

        // R9 switch off while in deep power-down
        cfg_write(2'b00, 3'b010, 2'b01, 2'b10);
        do_access(7, 1);
        repeat (6) @(negedge clk);
        chk(sd_cke == 1'b1, "R2 awake after switch-off", sd_cke, 1);
        chk(lat_q.size() == 0, "R6 grant queue drained", lat_q.size(), 0);
        chk(ent_q.size() == 0, "R9 entry queue drained", ent_q.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule